// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block is the fault-handling state machine of a switching regulator. On every switching-cycle tick it looks at the high-side and low-side current-limit flags and counts each cycle that carries a limit event. A short run of clean cycles forgives isolated events. A fault that persists is handled in three steps. First the inductor is drained through the low-side switch. Then both switches are held off for a fixed hiccup interval. Finally a fresh soft-start is requested.

An over-temperature flag overrides normal operation and holds both switches off until a cooled-down flag arrives. Dropping the enable returns the controller to idle from any state. The analog comparators that produce the flags are outside the block; only their digital results enter it.

Top module: `hiccup_guard`

## Requirements
- R1: After reset the controller is idle: fault_state = 0, force_off = 1, force_ls = 0, ss_restart = 0. With en high it enters the running state (fault_state = 1) on the next clock.
- R2: In the running state, each tick with hs_lim or ls_lim set counts exactly one event. A tick with both flags set still counts one.
- R3: An event arriving while the count is already 7 moves the controller to the drain state (fault_state = 2), where force_ls = 1 and force_off = 0.
- R4: Three consecutive ticks with no event clear the event count. Two clean ticks leave it unchanged.
- R5: In the drain state, the first tick with zero_x set moves the controller to the hiccup wait (fault_state = 3), where force_off = 1 and force_ls = 0.
- R6: If zero_x never comes, the drain state ends on its 64th tick and moves to the hiccup wait.
- R7: The hiccup wait lasts 1024 ticks. On the last one the controller returns to running with a count of zero, and ss_restart is high for exactly one clock.
- R8: Protection stays armed from the first cycle after a restart, so eight events right after ss_restart lead to the drain state again.
- R9: Current-limit flags have no effect during the hiccup wait. The wait is neither shortened nor lengthened by them.
- R10: With en high, hot moves the controller from running, drain or wait to thermal shutdown (fault_state = 4, force_off = 1) on the next clock. The controller stays there until cooled is seen. It then returns to running with a zero count and a one-clock ss_restart pulse.
- R11: en low moves the controller to idle on the next clock from any state and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable |
| tick | input | 1 | One-clock pulse marking each switching cycle |
| hs_lim | input | 1 | High-side current limit reached in this cycle |
| ls_lim | input | 1 | Low-side current limit reached in this cycle |
| zero_x | input | 1 | Inductor current has crossed zero |
| hot | input | 1 | Die over-temperature |
| cooled | input | 1 | Die has cooled by the hysteresis amount |
| force_ls | output | 1 | Hold the low-side switch on |
| force_off | output | 1 | Hold both switches off |
| ss_restart | output | 1 | One-clock request for a new soft-start |
| fault_state | output | 3 | 0 idle, 1 running, 2 drain, 3 hiccup wait, 4 thermal |

## Verification
The event count cannot be seen at the ports. Its value can only be inferred from how many further events it takes to reach the drain state. The stimulus therefore builds the count up to exactly seven and then adds clean ticks, hot/cooled cycles or enable drops. After each of these it probes with a single event or with a full run of seven events followed by an eighth. The 1024-tick wait and the 64-tick drain timeout are walked tick by tick, and the boundary one tick before each expiry is checked.

// File: rtl/hiccup_guard.sv
module hiccup_guard #(
  parameter int CNT_W     = 3,
  parameter int CLEAN_CYC = 3,
  parameter int DRAIN_TMO = 64,
  parameter int WAIT_CYC  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       hs_lim,
  input  logic       ls_lim,
  input  logic       zero_x,
  input  logic       hot,
  input  logic       cooled,
  output logic       force_ls,
  output logic       force_off,
  output logic       ss_restart,
  output logic [2:0] fault_state
);

  localparam int TMAX = (WAIT_CYC > DRAIN_TMO) ? WAIT_CYC : DRAIN_TMO;
  localparam int CLW  = $clog2(CLEAN_CYC + 1);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RUN   = 3'd1,
    S_DRAIN = 3'd2,
    S_WAIT  = 3'd3,
    S_THERM = 3'd4
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CLW-1:0]   clean;
  logic [TW-1:0]    tmr;

  wire evt = tick & (hs_lim | ls_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      clean      <= '0;
      tmr        <= '0;
      ss_restart <= 1'b0;
    end else begin
      ss_restart <= 1'b0;
      if (!en) begin
        st    <= S_IDLE;
        cnt   <= '0;
        clean <= '0;
        tmr   <= '0;
      end else if (hot && st != S_IDLE && st != S_THERM) begin
        st    <= S_THERM;
        cnt   <= '0;
        clean <= '0;
        tmr   <= '0;
      end else begin
        case (st)
          S_IDLE: st <= S_RUN;
          S_RUN: begin
            if (evt) begin
              clean <= '0;
              if (cnt == CNT_MAX) begin
                st  <= S_DRAIN;
                cnt <= '0;
                tmr <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (tick) begin
              if (clean == CLW'(CLEAN_CYC - 1)) begin
                clean <= '0;
                cnt   <= '0;
              end else begin
                clean <= clean + 1'b1;
              end
            end
          end
          S_DRAIN: begin
            if (tick) begin
              if (zero_x || tmr == TW'(DRAIN_TMO - 1)) begin
                st  <= S_WAIT;
                tmr <= '0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          S_WAIT: begin
            if (tick) begin
              if (tmr == TW'(WAIT_CYC - 1)) begin
                st         <= S_RUN;
                tmr        <= '0;
                cnt        <= '0;
                clean      <= '0;
                ss_restart <= 1'b1;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          S_THERM: begin
            if (cooled) begin
              st         <= S_RUN;
              ss_restart <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign force_ls    = (st == S_DRAIN);
  assign force_off   = (st == S_IDLE) || (st == S_WAIT) || (st == S_THERM);
  assign fault_state = st;

  p_drain_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hot && st == S_RUN && evt && cnt == CNT_MAX) |=> force_ls);

  p_wait_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && $past(st) != S_WAIT) |-> $past(st) == S_DRAIN);

  p_restart_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  p_restart_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> (st == S_RUN && cnt == '0));

  p_thermal_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hot && (st == S_RUN || st == S_DRAIN || st == S_WAIT)) |=> (st == S_THERM && force_off));

  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fault_state == 3'd0 && cnt == '0));

endmodule

// File: tb/hiccup_guard_tb.sv
module hiccup_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, tick = 1'b0, hs_lim = 1'b0, ls_lim = 1'b0, zero_x = 1'b0;
  logic hot = 1'b0, cooled = 1'b0;
  logic force_ls, force_off, ss_restart;
  logic [2:0] fault_state;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hiccup_guard u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .hs_lim(hs_lim), .ls_lim(ls_lim),
    .zero_x(zero_x), .hot(hot), .cooled(cooled), .force_ls(force_ls),
    .force_off(force_off), .ss_restart(ss_restart), .fault_state(fault_state)
  );

  // {hs, ls, zx, expected state}; covers R2 counting, R4 two clean ticks, R3 trip, R5 drain exit
  localparam logic [5:0] VEC [0:11] = '{
    6'b100_001, 6'b010_001, 6'b110_001, 6'b100_001,
    6'b010_001, 6'b100_001, 6'b100_001, 6'b000_001,
    6'b000_001, 6'b100_010, 6'b000_010, 6'b001_011
  };

  task automatic chk_st(input string req, input logic [2:0] exp);
    checks++;
    if (fault_state !== exp) begin
      fails++;
      $display("FAIL %s: fault_state=%0d expected %0d", req, fault_state, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s=%0b expected %0b", req, nm, act, exp);
    end
  endtask

  task automatic cyc(input logic h, input logic l, input logic z);
    @(negedge clk);
    hs_lim = h; ls_lim = l; zero_x = z; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; hs_lim = 1'b0; ls_lim = 1'b0; zero_x = 1'b0;
  endtask

  task automatic step(input logic h, input logic c);
    @(negedge clk);
    hot = h; cooled = c;
    @(negedge clk);
    hot = 1'b0; cooled = 1'b0;
  endtask

  task automatic events(input int n);
    for (int k = 0; k < n; k++) cyc(k[0], ~k[0], 1'b0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still active (actual timeout, expected completion)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_st("R1 reset", 3'd0);
    chk_bit("R1 reset", "force_off", force_off, 1'b1);
    chk_bit("R1 reset", "force_ls", force_ls, 1'b0);
    chk_bit("R1 reset", "ss_restart", ss_restart, 1'b0);
    en = 1'b1;
    @(negedge clk);
    chk_st("R1 enable", 3'd1);

    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i][5], VEC[i][4], VEC[i][3]);
      chk_st($sformatf("table row %0d (R2/R3/R4/R5)", i), VEC[i][2:0]);
    end
    chk_bit("R5 wait", "force_off", force_off, 1'b1);

    // R9: limit flags during the wait neither shorten nor extend it
    for (int i = 0; i < 1023; i++) cyc(1'b1, 1'b1, 1'b0);
    chk_st("R9 flags ignored in wait", 3'd3);
    cyc(1'b0, 1'b0, 1'b0);
    chk_st("R7 wait end", 3'd1);
    chk_bit("R7 restart pulse", "ss_restart", ss_restart, 1'b1);
    @(negedge clk);
    chk_bit("R7 single pulse", "ss_restart", ss_restart, 1'b0);

    // R8: armed right after restart
    events(7);
    chk_st("R8 seven after restart", 3'd1);
    events(1);
    chk_st("R8 eighth after restart", 3'd2);
    chk_bit("R3 drain", "force_ls", force_ls, 1'b1);

    // R6: drain timeout
    for (int i = 0; i < 63; i++) cyc(1'b0, 1'b0, 1'b0);
    chk_st("R6 before timeout", 3'd2);
    cyc(1'b0, 1'b0, 1'b0);
    chk_st("R6 timeout", 3'd3);

    // R10: thermal shutdown
    step(1'b1, 1'b0);
    chk_st("R10 hot from wait", 3'd4);
    chk_bit("R10 hot", "force_off", force_off, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    chk_st("R10 hold until cooled", 3'd4);
    step(1'b0, 1'b1);
    chk_st("R10 cooled restart", 3'd1);
    chk_bit("R10 restart pulse", "ss_restart", ss_restart, 1'b1);
    events(5);
    step(1'b1, 1'b0);
    chk_st("R10 hot from run", 3'd4);
    step(1'b0, 1'b1);
    events(7);
    chk_st("R10 count cleared", 3'd1);
    events(1);
    chk_st("R10 trip after clear", 3'd2);

    // R11: enable low from drain
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk_st("R11 disable", 3'd0);
    chk_bit("R11 disable", "force_ls", force_ls, 1'b0);
    en = 1'b1;
    @(negedge clk);
    chk_st("R11 re-enable", 3'd1);
    events(7);
    chk_st("R11 count cleared", 3'd1);
    events(1);
    chk_st("R11 trip after clear", 3'd2);

    // R4: three clean ticks clear the count
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    events(7);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0);
    events(7);
    chk_st("R4 three clean clear", 3'd1);
    events(1);
    chk_st("R4 trip after clear", 3'd2);

    finish_run();
  end
endmodule